// File: doc/BRIEF.md
# Clock Divider Factor Calculator

This block takes a parent clock rate and a requested output rate, both as unsigned 32-bit integers. It works out the settings for a two-stage divider. The first stage is a power-of-two prescaler with exponent `p` (0 to 3). The second stage is a linear divider whose count is written as `m` (count minus one, 4 bits). The block also reports the rate that those settings actually produce.

The calculation runs in several steps and shares one bit-serial integer divider. The first division gives the ratio. A small combinational stage then picks the prescaler and the linear count. A second division gives the achieved rate. A request is accepted with `start` while the block is idle. All results update together in the cycle when `done` pulses.

In the round-only mode, only the achieved rate is refreshed. Software can use it to ask what rate it would get without disturbing the stored settings.

Top module: `clkdiv_factor_calc`

## Requirements
- R1: When the requested rate is greater than the parent rate, the block uses the parent rate as the request. For example, parent 24000000 with request 50000000 gives p=0, m=0 and rate 24000000.
- R2: The ratio is the truncated quotient parent/request. The prescaler p is the smallest value in 0..2 for which ratio>>p is below 16, and 3 if there is none. So ratios 1..15 give p=0, 16..31 give p=1, 32..63 give p=2, and 64 or more give p=3.
- R3: The linear count is ratio/2^p rounded up. The m output equals that count minus one, in 4 bits.
- R4: The achieved rate is (parent >> p) divided by the linear count, truncated.
- R5: When p=3 and the rounded-up count exceeds 16, the count is limited to 16 (m=15). For example, parent 24000000 with request 100000 gives rate 187500.
- R6: A requested rate of zero selects p=3 and m=15, and the rate is (parent>>3)/16.
- R7: With `round_only` high at acceptance, only `rate_out` is updated. `p_out` and `m_out` keep their previous values.
- R8: `done` is high for exactly one cycle per accepted request. `p_out`, `m_out` and `rate_out` change only in that cycle and hold between results.
- R9: A `start` seen while a calculation is in progress is ignored. The request in progress completes with the values latched when it was accepted.
- R10: After reset, `done`, `p_out`, `m_out` and `rate_out` are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a calculation; accepted only when idle |
| round_only | input | 1 | Refresh only the achieved rate, keep p and m |
| parent_rate | input | 32 | Parent clock rate |
| target_rate | input | 32 | Requested output rate |
| done | output | 1 | One-cycle pulse when results are updated |
| p_out | output | 2 | Power-of-two prescaler exponent |
| m_out | output | 4 | Linear divide count minus one |
| rate_out | output | 32 | Achieved output rate |

## Verification
A request can finish and a new one can be accepted in the same cycle. The block returns to idle on the edge that raises `done`, so a `start` held high during that cycle is taken at once. The bench keeps `start` high across a whole calculation, changes the operands part-way through, and releases `start` one cycle after it sees `done`. It then expects the first result to reflect the original operands and a second result to follow for the changed operands. Each result must carry exactly one `done` pulse.

// File: rtl/clkdiv_factor_pkg.sv
// Package: shared widths, limits and controller state type for the
// clock divider factor calculator. Assumes rates fit in RATE_W bits.
package clkdiv_factor_pkg;
    localparam int RATE_W  = 32;                    // rate operand width
    localparam int P_MAX   = 3;                     // largest prescale exponent
    localparam int P_W     = $clog2(P_MAX + 1);     // p field width
    localparam int M_W     = 4;                     // m field width
    localparam int M_LIMIT = 1 << M_W;              // largest linear count
    localparam int CNT_W   = M_W + 1;               // width holding 1..M_LIMIT

    typedef enum logic [1:0] {
        ST_IDLE,   // waiting for a request
        ST_RATIO,  // dividing parent by request
        ST_PICK,   // choosing p and count, launching second division
        ST_RATE    // dividing prescaled parent by count
    } calc_state_t;
endpackage

// File: rtl/clkdiv_serial_div.sv
// Bit-serial restoring unsigned divider. One quotient bit per cycle, W
// cycles per division, 'fin' pulses one cycle after the last step.
// Assumes divisor is non-zero and 'go' only arrives when not running.
module clkdiv_serial_div #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         fin
);
    localparam int SW = $clog2(W);

    logic [W-1:0]  rem_q, quo_q, den_q;
    logic [SW-1:0] step_q;
    logic          run_q;
    logic [W:0]    shifted;
    logic [W-1:0]  diff;
    logic          ge;

    // Trial subtraction of the divisor from the shifted partial remainder
    always_comb begin
        shifted = {rem_q, quo_q[W-1]};
        ge      = shifted >= {1'b0, den_q};
        diff    = shifted[W-1:0] - den_q;
    end

    // Shift/subtract sequencing and completion pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            quo_q  <= '0;
            den_q  <= '0;
            step_q <= '0;
            run_q  <= 1'b0;
            fin    <= 1'b0;
        end else begin
            fin <= 1'b0;
            if (go) begin
                rem_q  <= '0;
                quo_q  <= dividend;
                den_q  <= divisor;
                step_q <= SW'(W - 1);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= ge ? diff : shifted[W-1:0];
                quo_q  <= {quo_q[W-2:0], ge};
                step_q <= step_q - 1'b1;
                if (step_q == '0) begin
                    run_q <= 1'b0;
                    fin   <= 1'b1;
                end
            end
        end
    end

    assign quotient = quo_q;
endmodule

// File: rtl/clkdiv_factor_sel.sv
// Combinational choice of prescale exponent and linear count from the
// integer ratio: smallest p bringing ratio>>p under M_LIMIT (else P_MAX),
// count = ceil(ratio / 2^p) limited to M_LIMIT.
module clkdiv_factor_sel
    import clkdiv_factor_pkg::*;
#(
    parameter int W = RATE_W
) (
    input  logic [W-1:0]     ratio,
    output logic [P_W-1:0]   p_sel,
    output logic [CNT_W-1:0] count
);
    logic [W:0] rounded;
    logic [W:0] ceil_v;

    // Pick the smallest exponent whose shifted ratio fits the linear stage
    always_comb begin
        p_sel = P_W'(P_MAX);
        for (int k = P_MAX - 1; k >= 0; k--) begin
            if ((ratio >> k) < W'(M_LIMIT)) p_sel = P_W'(k);
        end
    end

    // Round the linear count up and clamp it to the field range
    always_comb begin
        rounded = {1'b0, ratio} + (((W+1)'(1)) << p_sel) - (W+1)'(1);
        ceil_v  = rounded >> p_sel;
        count   = (ceil_v > (W+1)'(M_LIMIT)) ? CNT_W'(M_LIMIT) : ceil_v[CNT_W-1:0];
    end
endmodule

// File: rtl/clkdiv_factor_calc.sv
// Top: accepts parent/requested rates, runs ratio division, factor choice
// and achieved-rate division on one shared serial divider, then updates
// p/m/rate together with a one-cycle done pulse. Starts while busy are
// dropped.
module clkdiv_factor_calc
    import clkdiv_factor_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              round_only,
    input  logic [RATE_W-1:0] parent_rate,
    input  logic [RATE_W-1:0] target_rate,
    output logic              done,
    output logic [P_W-1:0]    p_out,
    output logic [M_W-1:0]    m_out,
    output logic [RATE_W-1:0] rate_out
);
    calc_state_t       state_q;
    logic              busy, accept, ro_q;
    logic [RATE_W-1:0] parent_q, ratio_q, tgt_eff;
    logic [P_W-1:0]    p_q, p_sel;
    logic [CNT_W-1:0]  cnt_q, count;
    logic              div_go, div_fin;
    logic [RATE_W-1:0] div_a, div_b, div_q;

    assign busy   = (state_q != ST_IDLE);
    assign accept = start && !busy;

    // Clamp the request to the parent rate
    always_comb tgt_eff = (target_rate > parent_rate) ? parent_rate : target_rate;

    // Divider launch and operand selection per phase
    always_comb begin
        div_go = (accept && tgt_eff != '0) || (state_q == ST_PICK);
        if (state_q == ST_IDLE) begin
            div_a = parent_rate;
            div_b = tgt_eff;
        end else begin
            div_a = parent_q >> p_sel;
            div_b = RATE_W'(count);
        end
    end

    clkdiv_factor_sel #(.W(RATE_W)) u_sel (
        .ratio (ratio_q),
        .p_sel (p_sel),
        .count (count)
    );

    clkdiv_serial_div #(.W(RATE_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .quotient (div_q),
        .fin      (div_fin)
    );

    // Phase sequencing and registered result update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            parent_q <= '0;
            ratio_q  <= '0;
            ro_q     <= 1'b0;
            p_q      <= '0;
            cnt_q    <= '0;
            done     <= 1'b0;
            p_out    <= '0;
            m_out    <= '0;
            rate_out <= '0;
        end else begin
            done <= 1'b0;
            unique case (state_q)
                ST_IDLE: if (accept) begin
                    parent_q <= parent_rate;
                    ro_q     <= round_only;
                    if (tgt_eff == '0) begin
                        ratio_q <= '1;
                        state_q <= ST_PICK;
                    end else begin
                        state_q <= ST_RATIO;
                    end
                end
                ST_RATIO: if (div_fin) begin
                    ratio_q <= div_q;
                    state_q <= ST_PICK;
                end
                ST_PICK: begin
                    p_q     <= p_sel;
                    cnt_q   <= count;
                    state_q <= ST_RATE;
                end
                ST_RATE: if (div_fin) begin
                    rate_out <= div_q;
                    if (!ro_q) begin
                        p_out <= p_q;
                        m_out <= M_W'(cnt_q - 1'b1);
                    end
                    done    <= 1'b1;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/clkdiv_factor_calc_chk.sv
// Checker for clkdiv_factor_calc: latches each accepted request from the
// ports and relates it to the results at done. Attached by bind below.
module clkdiv_factor_calc_chk
    import clkdiv_factor_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              round_only,
    input logic [RATE_W-1:0] parent_rate,
    input logic [RATE_W-1:0] target_rate,
    input logic              busy,
    input logic              done,
    input logic [P_W-1:0]    p_out,
    input logic [M_W-1:0]    m_out,
    input logic [RATE_W-1:0] rate_out
);
    logic [RATE_W-1:0] par_l, tgt_l;
    logic              ro_l;

    // Capture the operands of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            par_l <= '0;
            tgt_l <= '0;
            ro_l  <= 1'b0;
        end else if (start && !busy) begin
            par_l <= parent_rate;
            tgt_l <= target_rate;
            ro_l  <= round_only;
        end
    end

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    // R7
    round_keeps_pm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && ro_l) |-> ($stable(p_out) && $stable(m_out)));

    // R4
    rate_formula_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ro_l) |-> (rate_out == ((par_l >> p_out) / (RATE_W'(m_out) + 1))));

    // R1
    clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ro_l && par_l != '0 && tgt_l >= par_l)
            |-> (p_out == '0 && m_out == '0 && rate_out == par_l));

    // R2
    prescale_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !ro_l && p_out != '0) |-> (m_out >= M_W'(M_LIMIT / 2 - 1)));
endmodule

bind clkdiv_factor_calc clkdiv_factor_calc_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .round_only  (round_only),
    .parent_rate (parent_rate),
    .target_rate (target_rate),
    .busy        (busy),
    .done        (done),
    .p_out       (p_out),
    .m_out       (m_out),
    .rate_out    (rate_out)
);

// File: tb/clkdiv_factor_calc_tb.sv
module clkdiv_factor_calc_tb;
    localparam int CLK_P = 10;

    typedef struct packed {
        logic [31:0] par;
        logic [31:0] tgt;
        logic [1:0]  p;
        logic [3:0]  m;
        logic [31:0] rate;
    } vec_t;

    localparam int NV = 15;
    localparam vec_t VECS [NV] = '{
        '{32'd24000000, 32'd24000000, 2'd0, 4'd0,  32'd24000000},
        '{32'd24000000, 32'd50000000, 2'd0, 4'd0,  32'd24000000},
        '{32'd24000000, 32'd2000000,  2'd0, 4'd11, 32'd2000000},
        '{32'd24000000, 32'd1000000,  2'd1, 4'd11, 32'd1000000},
        '{32'd24000000, 32'd700000,   2'd2, 4'd8,  32'd666666},
        '{32'd24000000, 32'd400000,   2'd2, 4'd14, 32'd400000},
        '{32'd24000000, 32'd300000,   2'd3, 4'd9,  32'd300000},
        '{32'd24000000, 32'd100000,   2'd3, 4'd15, 32'd187500},
        '{32'd100,      32'd30,       2'd0, 4'd2,  32'd33},
        '{32'd1000,     32'd62,       2'd1, 4'd7,  32'd62},
        '{32'd1000,     32'd31,       2'd2, 4'd7,  32'd31},
        '{32'd1000,     32'd15,       2'd3, 4'd8,  32'd13},
        '{32'd1000,     32'd17,       2'd2, 4'd14, 32'd16},
        '{32'hFFFFFFFF, 32'd1,        2'd3, 4'd15, 32'd33554431},
        '{32'd1000,     32'd40,       2'd1, 4'd12, 32'd38}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        round_only = 1'b0;
    logic [31:0] parent_rate = '0;
    logic [31:0] target_rate = '0;
    logic        done;
    logic [1:0]  p_out;
    logic [3:0]  m_out;
    logic [31:0] rate_out;

    int tests = 0;
    int fails = 0;

    always #(CLK_P/2) clk = ~clk;

    clkdiv_factor_calc u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .round_only(round_only),
        .parent_rate(parent_rate), .target_rate(target_rate),
        .done(done), .p_out(p_out), .m_out(m_out), .rate_out(rate_out)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 500) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic run_calc(input logic [31:0] par, input logic [31:0] tgt, input logic ro);
        @(negedge clk);
        parent_rate = par;
        target_rate = tgt;
        round_only  = ro;
        start       = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
    endtask

    initial begin
        #(CLK_P * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk("R10 done", 32'(done), 0);
        chk("R10 p", 32'(p_out), 0);
        chk("R10 m", 32'(m_out), 0);
        chk("R10 rate", rate_out, 0);
        rst_n = 1'b1;

        // R1..R5: vector table
        for (int i = 0; i < NV; i++) begin
            run_calc(VECS[i].par, VECS[i].tgt, 1'b0);
            chk($sformatf("R2 p vec%0d", i), 32'(p_out), 32'(VECS[i].p));
            chk($sformatf("R3 m vec%0d", i), 32'(m_out), 32'(VECS[i].m));
            chk($sformatf("R4 rate vec%0d", i), rate_out, VECS[i].rate);
            @(negedge clk);
            // R8: single-cycle pulse, outputs hold
            chk($sformatf("R8 pulse vec%0d", i), 32'(done), 0);
            chk($sformatf("R8 hold vec%0d", i), rate_out, VECS[i].rate);
        end

        // R1: clamp check on the above-parent entry
        run_calc(32'd5000, 32'd9000, 1'b0);
        chk("R1 p", 32'(p_out), 0);
        chk("R1 m", 32'(m_out), 0);
        chk("R1 rate", rate_out, 32'd5000);

        // R5: count clamp at p=3
        run_calc(32'd1000000, 32'd1000, 1'b0);
        chk("R5 m", 32'(m_out), 15);
        chk("R5 rate", rate_out, 32'd7812);

        // R6: zero request
        run_calc(32'd24000000, 32'd0, 1'b0);
        chk("R6 p", 32'(p_out), 3);
        chk("R6 m", 32'(m_out), 15);
        chk("R6 rate", rate_out, 32'd187500);

        // R7: round-only keeps p and m
        run_calc(32'd1000, 32'd40, 1'b0);
        run_calc(32'd24000000, 32'd100000, 1'b1);
        chk("R7 rate", rate_out, 32'd187500);
        chk("R7 p kept", 32'(p_out), 1);
        chk("R7 m kept", 32'(m_out), 12);

        // R9: start held through a run, operands changed mid-run
        @(negedge clk);
        parent_rate = 32'd1000;
        target_rate = 32'd62;
        round_only  = 1'b0;
        start       = 1'b1;
        repeat (5) @(negedge clk);
        parent_rate = 32'd24000000;
        target_rate = 32'd2000000;
        wait_done();
        chk("R9 first p", 32'(p_out), 1);
        chk("R9 first m", 32'(m_out), 7);
        chk("R9 first rate", rate_out, 32'd62);
        @(negedge clk);
        start = 1'b0;
        chk("R8 no double done", 32'(done), 0);
        wait_done();
        chk("R9 second p", 32'(p_out), 0);
        chk("R9 second m", 32'(m_out), 11);
        chk("R9 second rate", rate_out, 32'd2000000);
        @(negedge clk);
        chk("R8 pulse end", 32'(done), 0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule